// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

The block holds two interval timers behind a small byte-wide register window. Each timer counts up from a programmable preload, one step per fixed number of microsecond ticks (80 ticks for timer 1, 320 ticks for timer 2 by default). It expires when it steps past 0xFF, reloads the preload and keeps running for as long as its start bit stays set.

Each expiry can raise two kinds of flag. The maskable flags live only in the timer status byte and are suppressed by per-timer mask bits. The non-maskable flags appear both in the timer status byte and in a shared interrupt status byte, gated by per-timer enables in the control register. The interrupt request is high whenever any shared bit is set.

Software clears the maskable flags by writing the data register with bit 7 set. It clears the non-maskable flags by dropping the matching enable bit. The status address returns either the timer status or a plain byte that software stored there, chosen by a control bit.

Top module: `dual_interval_timer`

## Requirements
- R1: While rst_ni is low, the control, data, preload and plain-status registers are zero, and tmr_status_o, irq_stat_o and irq_o are zero.
- R2: The register window decodes addr_i as follows: 0 control, 1 data, 2 timer 1 preload, 3 timer 2 preload, 4 status, 5 shared interrupt status (read only). A write when wr_i is high stores wdata_i, and rdata_o returns the stored value of the addressed register combinationally.
- R3: A read of address 4 returns tmr_status_o when control bit 0 is 1, and otherwise returns the byte last written to address 4.
- R4: While its start bit is set (data bit 0 for timer 1, data bit 1 for timer 2), a timer advances once every T1_TICKS or T2_TICKS ticks. It expires on the step taken from 0xFF, reloads its preload and continues. With a tick on every cycle and preload P, the first expiry falls (256-P)*T cycles after the edge that sets the start bit, and later expiries follow every (256-P)*T cycles.
- R5: A timer 1 expiry sets status bits 7 and 6 unless data bit 6 (timer 1 mask) is set.
- R6: A timer 2 expiry sets status bits 7 and 5 unless data bit 5 (timer 2 mask) is set.
- R7: A timer 1 expiry with control bit 2 set sets status bit 2 and shared bit 2.
- R8: A timer 2 expiry with control bit 3 set sets status bit 1 and shared bit 3.
- R9: A control write with bit 2 clear clears status bit 2 and shared bit 2. A control write with bit 3 clear clears status bit 1 and shared bit 3.
- R10: A data write with bit 7 set clears status bits 7..5, leaves the other status bits and the stored data value unchanged, and wins over an expiry on the same edge.
- R11: irq_o is 1 exactly when irq_stat_o is nonzero.
- R12: With its start bit clear, a timer holds its count at the preload and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| tmr_status_o | output | 8 | Timer status byte |
| irq_stat_o | output | 8 | Shared interrupt status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench places the expiry edge to the cycle, one edge early and on the edge itself. A prescaler that is off by one, or a counter that expires on reaching 0xFF rather than on leaving it, shows up as a flag one period early or late. It lands a clearing data write on the same edge as an expiry, so a design that applies the set after the clear leaves bits 7..6 standing. It runs both timers so that they expire together, and it drops one enable while the other stays set, which catches a design that clears both non-maskable flags or the wrong shared bit. Masked runs must still raise the non-maskable flags, and a stopped timer must stay silent over several periods.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 3;
  localparam int unsigned NTMR = 2;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [AW-1:0] {
    REG_CTRL = 3'd0,
    REG_DATA = 3'd1,
    REG_PRE1 = 3'd2,
    REG_PRE2 = 3'd3,
    REG_STAT = 3'd4,
    REG_IRQ  = 3'd5
  } reg_addr_e;

  localparam int unsigned STAT_SEL_BIT = 0;
  localparam int unsigned DATA_CLR_BIT = 7;
  localparam int unsigned ANY_FLAG_BIT = 7;

  function automatic int unsigned start_bit(int unsigned t);
    return t;
  endfunction

  function automatic int unsigned mask_bit(int unsigned t);
    return (t == 0) ? 6 : 5;
  endfunction

  function automatic int unsigned mflag_bit(int unsigned t);
    return (t == 0) ? 6 : 5;
  endfunction

  function automatic int unsigned nflag_bit(int unsigned t);
    return (t == 0) ? 2 : 1;
  endfunction

  function automatic int unsigned shared_bit(int unsigned t);
    return (t == 0) ? 2 : 3;
  endfunction

  function automatic int unsigned en_bit(int unsigned t);
    return (t == 0) ? 2 : 3;
  endfunction
endpackage

// File: rtl/dit_timer.sv
module dit_timer #(
  parameter int unsigned TICKS = 80,
  parameter int unsigned CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] preload_i,
  output logic          expire_o
);
  localparam int unsigned PW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          step;

  assign step     = run_i & tick_i & (pre_q == PRE_LAST);
  assign expire_o = step & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      // stopped: hold phase and count at start values
      pre_q <= '0;
      cnt_q <= preload_i;
    end else if (tick_i) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (step) cnt_q <= expire_o ? preload_i : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  input  byte_t               wdata_i,
  input  byte_t               tmr_status_i,
  input  byte_t               irq_stat_i,
  output byte_t               ctrl_o,
  output byte_t               data_o,
  output logic [NTMR-1:0][DW-1:0] preload_o,
  output logic                ctrl_wr_o,
  output logic                data_clr_o,
  output byte_t               rdata_o
);
  byte_t ctrl_q, data_q, plain_q;
  logic [NTMR-1:0][DW-1:0] pre_q;
  logic data_wr;

  assign ctrl_wr_o  = wr_i && (addr_i == REG_CTRL);
  assign data_wr    = wr_i && (addr_i == REG_DATA);
  assign data_clr_o = data_wr && wdata_i[DATA_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      plain_q <= '0;
      pre_q   <= '0;
    end else if (wr_i) begin
      if (ctrl_wr_o) ctrl_q <= wdata_i;
      if (data_wr && !wdata_i[DATA_CLR_BIT]) data_q <= wdata_i;
      if (addr_i == REG_PRE1) pre_q[0] <= wdata_i;
      if (addr_i == REG_PRE2) pre_q[1] <= wdata_i;
      if (addr_i == REG_STAT) plain_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_CTRL: rdata_o = ctrl_q;
      REG_DATA: rdata_o = data_q;
      REG_PRE1: rdata_o = pre_q[0];
      REG_PRE2: rdata_o = pre_q[1];
      REG_STAT: rdata_o = ctrl_q[STAT_SEL_BIT] ? tmr_status_i : plain_q;
      REG_IRQ:  rdata_o = irq_stat_i;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign data_o    = data_q;
  assign preload_o = pre_q;
endmodule

// File: rtl/dit_status.sv
module dit_status
  import dit_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NTMR-1:0] expire_i,
  input  logic [NTMR-1:0] mask_i,
  input  logic [NTMR-1:0] en_i,
  input  logic            ctrl_wr_i,
  input  byte_t           ctrl_wdata_i,
  input  logic            data_clr_i,
  output byte_t           tmr_status_o,
  output byte_t           irq_stat_o
);
  byte_t st_q, st_d, sh_q, sh_d;

  always_comb begin
    st_d = st_q;
    sh_d = sh_q;
    for (int t = 0; t < NTMR; t++) begin
      if (expire_i[t]) begin
        if (!mask_i[t]) begin
          st_d[ANY_FLAG_BIT] = 1'b1;
          st_d[mflag_bit(t)] = 1'b1;
        end
        if (en_i[t]) begin
          st_d[nflag_bit(t)]  = 1'b1;
          sh_d[shared_bit(t)] = 1'b1;
        end
      end
      if (ctrl_wr_i && !ctrl_wdata_i[en_bit(t)]) begin
        st_d[nflag_bit(t)]  = 1'b0;
        sh_d[shared_bit(t)] = 1'b0;
      end
    end
    // clear is applied last so it wins over a same-edge expiry
    if (data_clr_i) begin
      st_d[ANY_FLAG_BIT] = 1'b0;
      for (int t = 0; t < NTMR; t++) st_d[mflag_bit(t)] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      sh_q <= '0;
    end else begin
      st_q <= st_d;
      sh_q <= sh_d;
    end
  end

  assign tmr_status_o = st_q;
  assign irq_stat_o   = sh_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned T1_TICKS = 80,
  parameter int unsigned T2_TICKS = 320
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       us_tick_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] tmr_status_o,
  output logic [7:0] irq_stat_o,
  output logic       irq_o
);
  byte_t ctrl_q, data_q;
  logic [NTMR-1:0][DW-1:0] preload;
  logic [NTMR-1:0] run, mask, en, expire;
  logic ctrl_wr, data_clr;

  dit_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .tmr_status_i (tmr_status_o),
    .irq_stat_i   (irq_stat_o),
    .ctrl_o       (ctrl_q),
    .data_o       (data_q),
    .preload_o    (preload),
    .ctrl_wr_o    (ctrl_wr),
    .data_clr_o   (data_clr),
    .rdata_o      (rdata_o)
  );

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    localparam int unsigned TK = (g == 0) ? T1_TICKS : T2_TICKS;
    assign run[g]  = data_q[start_bit(g)];
    assign mask[g] = data_q[mask_bit(g)];
    assign en[g]   = ctrl_q[en_bit(g)];

    dit_timer #(.TICKS(TK), .CW(DW)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run[g]),
      .tick_i    (us_tick_i),
      .preload_i (preload[g]),
      .expire_o  (expire[g])
    );
  end

  dit_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .mask_i       (mask),
    .en_i         (en),
    .ctrl_wr_i    (ctrl_wr),
    .ctrl_wdata_i (wdata_i),
    .data_clr_i   (data_clr),
    .tmr_status_o (tmr_status_o),
    .irq_stat_o   (irq_stat_o)
  );

  assign irq_o = |irq_stat_o;
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_i,
  input logic [2:0]      addr_i,
  input logic [7:0]      wdata_i,
  input logic [7:0]      ctrl_q,
  input logic [7:0]      data_q,
  input logic [NTMR-1:0] run,
  input logic [NTMR-1:0] expire,
  input logic [7:0]      tmr_status_o,
  input logic [7:0]      irq_stat_o,
  input logic            irq_o
);
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o == 8'h00) |-> !irq_o); // R11
  AST_IRQ_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o != 8'h00) |-> irq_o); // R11
  AST_T1_SHARED_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[2] == tmr_status_o[2]); // R7
  AST_T2_SHARED_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[3] == tmr_status_o[1]); // R8
  AST_T1_NM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[2] |-> ctrl_q[2]); // R9
  AST_T2_NM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stat_o[3] |-> ctrl_q[3]); // R9
  AST_MASK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DATA && wdata_i[7]) |=> (tmr_status_o[7:5] == 3'b000)); // R10
  AST_T1_STOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run[0] |-> !expire[0]); // R12
  AST_T2_STOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run[1] |-> !expire[1]); // R12
  AST_T1_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_status_o[6]) |-> !$past(data_q[6])); // R5
  AST_T2_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_status_o[5]) |-> !$past(data_q[5])); // R6
endmodule

bind dual_interval_timer dit_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .ctrl_q       (ctrl_q),
  .data_q       (data_q),
  .run          (run),
  .expire       (expire),
  .tmr_status_o (tmr_status_o),
  .irq_stat_o   (irq_stat_o),
  .irq_o        (irq_o)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  import dit_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       us_tick_i = 1'b1;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, tmr_status_o, irq_stat_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_interval_timer u_dual_interval_timer (
    .clk_i, .rst_ni, .us_tick_i, .wr_i, .addr_i, .wdata_i,
    .rdata_o, .tmr_status_o, .irq_stat_o, .irq_o
  );

  // {wr, addr, wdata, expected read of addr}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'hF0, 8'hF0},   // R2 control
    {1'b1, 3'd2, 8'h12, 8'h12},   // R2 preload 1
    {1'b1, 3'd3, 8'hAB, 8'hAB},   // R2 preload 2
    {1'b1, 3'd1, 8'h64, 8'h64},   // R2 data, no start bit
    {1'b1, 3'd1, 8'h80, 8'h64},   // R10 clear write not stored
    {1'b1, 3'd4, 8'h5A, 8'h5A},   // R3 plain byte
    {1'b1, 3'd0, 8'h01, 8'h01},   // R3 select timer status
    {1'b0, 3'd4, 8'h00, 8'h00},   // R3 timer status is zero
    {1'b1, 3'd0, 8'h00, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h5A},   // R3 back to plain byte
    {1'b0, 3'd5, 8'h00, 8'h00},   // R2 shared status idle
    {1'b1, 3'd1, 8'h00, 8'h00}
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    check(req, "read", rdata_o, exp);
  endtask

  task automatic skip(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    skip(2);
    #1;
    check("R1", "status in reset", tmr_status_o, 8'h00);
    check("R1", "shared in reset", irq_stat_o, 8'h00);
    check("R1", "irq in reset", {7'd0, irq_o}, 8'h00);
    rd_chk("R1", REG_CTRL, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      rd_chk("R2", VEC[i][18:16], VEC[i][7:0]);
    end

    // timer 1, preload FE: expiries at 160 and 320
    wr(REG_PRE1, 8'hFE);
    wr(REG_CTRL, 8'h04);
    wr(REG_DATA, 8'h01);
    settle(159);
    check("R4", "t1 before expiry", tmr_status_o, 8'h00);
    settle(1);
    check("R5", "t1 expiry status", tmr_status_o, 8'hC4);
    check("R7", "t1 shared", irq_stat_o, 8'h04);
    check("R11", "irq raised", {7'd0, irq_o}, 8'h01);
    skip(39);
    wr(REG_DATA, 8'h80);
    check("R10", "maskable cleared", tmr_status_o, 8'h04);
    rd_chk("R10", REG_DATA, 8'h01);
    settle(119);
    check("R4", "t1 before reload expiry", tmr_status_o, 8'h04);
    settle(1);
    check("R4", "t1 reload expiry", tmr_status_o, 8'hC4);
    wr(REG_CTRL, 8'h00);
    check("R9", "t1 nm cleared", tmr_status_o, 8'hC0);
    check("R9", "t1 shared cleared", irq_stat_o, 8'h00);
    check("R11", "irq dropped", {7'd0, irq_o}, 8'h00);
    wr(REG_DATA, 8'h00);
    wr(REG_DATA, 8'h80);
    settle(400);
    check("R12", "stopped timer silent", tmr_status_o, 8'h00);

    // timer 1 masked
    wr(REG_PRE1, 8'hFF);
    wr(REG_CTRL, 8'h04);
    wr(REG_DATA, 8'h41);
    settle(80);
    check("R5", "t1 masked", tmr_status_o, 8'h04);
    check("R7", "t1 masked shared", irq_stat_o, 8'h04);
    wr(REG_CTRL, 8'h00);
    wr(REG_DATA, 8'h00);
    check("R9", "cleared after mask run", tmr_status_o, 8'h00);

    // both timers, preload FF: t1 every 80, t2 at 320
    wr(REG_PRE2, 8'hFF);
    wr(REG_CTRL, 8'h0C);
    wr(REG_DATA, 8'h03);
    settle(319);
    check("R4", "t2 before expiry", tmr_status_o, 8'hC4);
    settle(1);
    check("R6", "both expired", tmr_status_o, 8'hE6);
    check("R8", "both shared", irq_stat_o, 8'h0C);
    wr(REG_CTRL, 8'h04);
    check("R9", "t2 nm cleared only", tmr_status_o, 8'hE4);
    check("R9", "t2 shared cleared only", irq_stat_o, 8'h04);
    wr(REG_DATA, 8'h00);
    wr(REG_DATA, 8'h80);
    check("R10", "nm kept by clear", tmr_status_o, 8'h04);
    wr(REG_CTRL, 8'h00);

    // timer 2 masked
    wr(REG_CTRL, 8'h08);
    wr(REG_DATA, 8'h22);
    settle(319);
    check("R12", "t2 masked before expiry", tmr_status_o, 8'h00);
    settle(1);
    check("R6", "t2 masked", tmr_status_o, 8'h02);
    check("R8", "t2 shared", irq_stat_o, 8'h08);
    rd_chk("R8", REG_IRQ, 8'h08);
    wr(REG_DATA, 8'h00);
    wr(REG_CTRL, 8'h00);

    // clear on the same edge as an expiry
    wr(REG_DATA, 8'h01);
    skip(159);
    wr(REG_DATA, 8'h80);
    check("R10", "clear wins same edge", tmr_status_o, 8'h00);
    settle(79);
    check("R10", "after same-edge clear", tmr_status_o, 8'h00);
    settle(1);
    check("R4", "t1 keeps running", tmr_status_o, 8'hC0);

    // reset while running
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", "status after reset", tmr_status_o, 8'h00);
    rd_chk("R1", REG_DATA, 8'h00);
    check("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog expired");
      summary();
      $finish;
    end
  end
endmodule